// File: doc/BRIEF.md
# UART Automatic Powerdown Controller

This block decides when the transmit half and the receive half of a UART may each drop into a low-power state, and when each must wake. Each half has its own idle condition and its own wake event, so one half can sleep while the other works. The transmit half sleeps once its holding buffer and shift register are both empty. It wakes on a host write to the transmit buffer. The receive half sleeps once its FIFO is empty and the receiver is hunting for a start bit. It wakes when the serial input line changes level.

Automatic sleep is armed only while every bit of the auto-power enable field is set. Clearing any of those bits brings both halves awake in the same cycle. A separate force input per half asserts powerdown no matter what the automatic logic decides.

The ring-indicator input goes through its own synchronizer and edge detector. Any change of level raises an interrupt request that stays set until a clear pulse arrives. This works whether or not either half is powered down.

Top module: `uart_auto_pd`

## Requirements
- R1: While reset is held and just after release, `ri_irq` is 0 and each powerdown output equals its force input.
- R2: Automatic powerdown happens only when all `EN_BITS` bits of `cfg_auto_en` are 1. With any bit at 0, `tx_pd` equals `force_pd_tx` and `rx_pd` equals `force_pd_rx`.
- R3: The transmit half enters powerdown at the first clock edge that samples the enable armed, `thr_empty`=1, `tsr_empty`=1 and no `thr_wr`. `tx_pd` is still 0 before that edge.
- R4: If `thr_empty` or `tsr_empty` is 0 at an edge, `tx_pd` is 0 after that edge, unless it is forced.
- R5: A `thr_wr` pulse drives `tx_pd` to 0 in the same cycle, combinationally. The half then stays awake for the following cycle.
- R6: The receive half enters powerdown at the first edge that samples the enable armed with `rx_fifo_empty`=1 and `rx_hunt`=1. If either is 0 at an edge, `rx_pd` is 0 after it, unless it is forced.
- R7: A level change on `rx_line` passes through `SYNC_STAGES` flops and then an edge detector. `rx_pd` goes to 0 for the cycle after the `SYNC_STAGES`-th edge following the change, and stays 0 for the next cycle. After that it re-enters powerdown if the half is still idle.
- R8: A level change on `ring_in`, in either direction, sets `ri_irq` at the (`SYNC_STAGES`+1)-th edge after the change, whatever the powerdown state. `ri_irq` stays set until an edge samples `ri_int_clr`=1. A new ring event and a clear in the same cycle leave it set.
- R9: Clearing the enable drops both `tx_pd` and `rx_pd` in the same cycle, combinationally, when they are not forced.
- R10: `force_pd_tx`=1 makes `tx_pd` 1 and `force_pd_rx`=1 makes `rx_pd` 1, each in the same cycle, whatever the enable and idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_en | input | EN_BITS | Auto-power enable field; armed when all bits are 1 |
| force_pd_tx | input | 1 | Direct override: force transmit powerdown |
| force_pd_rx | input | 1 | Direct override: force receive powerdown |
| thr_empty | input | 1 | Transmit holding buffer empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| rx_hunt | input | 1 | Receiver waiting for a start bit |
| thr_wr | input | 1 | Host write strobe to the transmit buffer |
| rx_line | input | 1 | Asynchronous serial receive line |
| ring_in | input | 1 | Asynchronous ring-indicator input |
| ri_int_clr | input | 1 | Status-read pulse that clears the ring interrupt |
| tx_pd | output | 1 | Transmit half powerdown |
| rx_pd | output | 1 | Receive half powerdown |
| ri_irq | output | 1 | Latched ring-indicator interrupt request |

## Verification
Each half keeps only one bit of sleep state. If that bit is wrong, the matching powerdown output shows it at the next edge, because entry and exit are one clock apart. A synchronizer chain of the wrong length moves the `rx_pd` dip and the `ri_irq` rise by whole cycles. The bench therefore samples those outputs at exact cycle counts after the input change. A wrong latch priority or hold shows as `ri_irq` dropping, or failing to drop, in the cycle after a clear pulse.

// File: rtl/uart_apd_pkg.sv
package uart_apd_pkg;
   typedef enum logic {
      PD_AWAKE  = 1'b0,
      PD_ASLEEP = 1'b1
   } pd_state_e;

   localparam int MIN_SYNC_STAGES = 2;
   localparam int MAX_SYNC_STAGES = 8;
endpackage

// File: rtl/apd_sync_edge.sv
module apd_sync_edge #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic change
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < uart_apd_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("apd_sync_edge: STAGES below minimum");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
         prev  <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign change = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/apd_half_ctl.sv
module apd_half_ctl #(
   parameter bit COMB_WAKE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic idle,
   input  logic wake,
   input  logic force_pd,
   output logic pd
);
   import uart_apd_pkg::*;

   pd_state_e state_q, state_d;
   logic      sleep_ok;

   always_comb begin
      if (!armed || wake || !idle) state_d = PD_AWAKE;
      else                         state_d = PD_ASLEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PD_AWAKE;
      else        state_q <= state_d;
   end

   generate
      if (COMB_WAKE) begin : g_comb_wake
         assign sleep_ok = (state_q == PD_ASLEEP) && armed && !wake;
      end else begin : g_reg_wake
         assign sleep_ok = (state_q == PD_ASLEEP) && armed;
      end
   endgenerate

   assign pd = force_pd | sleep_ok;
endmodule

// File: rtl/apd_ring_latch.sv
module apd_ring_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);
   logic irq_d;

   generate
      if (SET_WINS) begin : g_set_first
         assign irq_d = set | (irq & ~clr);
      end else begin : g_clr_first
         assign irq_d = ~clr & (set | irq);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_d;
   end
endmodule

// File: rtl/uart_auto_pd.sv
module uart_auto_pd #(
   parameter int   EN_BITS     = 2,
   parameter int   SYNC_STAGES = 2,
   parameter logic RXD_IDLE    = 1'b1,
   parameter logic RI_IDLE     = 1'b0,
   parameter bit   WAKE_COMB   = 1'b1,
   parameter bit   RI_SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EN_BITS-1:0] cfg_auto_en,
   input  logic               force_pd_tx,
   input  logic               force_pd_rx,
   input  logic               thr_empty,
   input  logic               tsr_empty,
   input  logic               rx_fifo_empty,
   input  logic               rx_hunt,
   input  logic               thr_wr,
   input  logic               rx_line,
   input  logic               ring_in,
   input  logic               ri_int_clr,
   output logic               tx_pd,
   output logic               rx_pd,
   output logic               ri_irq
);
   localparam logic [EN_BITS-1:0] ARM_PATTERN = {EN_BITS{1'b1}};

   generate
      if (EN_BITS < 1) begin : g_bad_en
         $error("uart_auto_pd: EN_BITS must be at least 1");
      end
      if (SYNC_STAGES > uart_apd_pkg::MAX_SYNC_STAGES) begin : g_bad_sync
         $error("uart_auto_pd: SYNC_STAGES too large");
      end
   endgenerate

   logic armed;
   logic tx_idle;
   logic rx_idle;
   logic rx_change;
   logic ri_change;

   assign armed   = (cfg_auto_en == ARM_PATTERN);
   assign tx_idle = thr_empty & tsr_empty;
   assign rx_idle = rx_fifo_empty & rx_hunt;

   apd_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(RXD_IDLE)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_line), .change(rx_change)
   );

   apd_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(RI_IDLE)) u_ri_sync (
      .clk(clk), .rst_n(rst_n), .din(ring_in), .change(ri_change)
   );

   apd_half_ctl #(.COMB_WAKE(WAKE_COMB)) u_tx_half (
      .clk(clk), .rst_n(rst_n), .armed(armed), .idle(tx_idle),
      .wake(thr_wr), .force_pd(force_pd_tx), .pd(tx_pd)
   );

   apd_half_ctl #(.COMB_WAKE(WAKE_COMB)) u_rx_half (
      .clk(clk), .rst_n(rst_n), .armed(armed), .idle(rx_idle),
      .wake(rx_change), .force_pd(force_pd_rx), .pd(rx_pd)
   );

   apd_ring_latch #(.SET_WINS(RI_SET_WINS)) u_ring (
      .clk(clk), .rst_n(rst_n), .set(ri_change), .clr(ri_int_clr), .irq(ri_irq)
   );
endmodule

// File: rtl/uart_auto_pd_chk.sv
module uart_auto_pd_chk #(
   parameter int EN_BITS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [EN_BITS-1:0] cfg_auto_en,
   input logic               force_pd_tx,
   input logic               force_pd_rx,
   input logic               thr_empty,
   input logic               tsr_empty,
   input logic               rx_fifo_empty,
   input logic               rx_hunt,
   input logic               thr_wr,
   input logic               ri_int_clr,
   input logic               tx_pd,
   input logic               rx_pd,
   input logic               ri_irq
);
   logic arm;
   assign arm = &cfg_auto_en;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!ri_irq && tx_pd == force_pd_tx && rx_pd == force_pd_rx));

   p_unarmed_follow_r2_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |-> (tx_pd == force_pd_tx && rx_pd == force_pd_rx));

   p_tx_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && thr_empty && tsr_empty && !thr_wr) ##1 (arm && !thr_wr) |-> tx_pd);

   p_tx_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(thr_empty && tsr_empty) |=> (!tx_pd || force_pd_tx));

   p_tx_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !force_pd_tx) |-> !tx_pd);

   p_rx_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_fifo_empty && rx_hunt) |=> (!rx_pd || force_pd_rx));

   p_ri_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ri_irq && !ri_int_clr) |=> ri_irq);

   p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (force_pd_tx |-> tx_pd) and (force_pd_rx |-> rx_pd));
endmodule

bind uart_auto_pd uart_auto_pd_chk #(.EN_BITS(EN_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_auto_en(cfg_auto_en),
   .force_pd_tx(force_pd_tx), .force_pd_rx(force_pd_rx),
   .thr_empty(thr_empty), .tsr_empty(tsr_empty),
   .rx_fifo_empty(rx_fifo_empty), .rx_hunt(rx_hunt), .thr_wr(thr_wr),
   .ri_int_clr(ri_int_clr), .tx_pd(tx_pd), .rx_pd(rx_pd), .ri_irq(ri_irq)
);

// File: tb/uart_auto_pd_bench.sv
module uart_auto_pd_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_auto_en = 2'b00;
   logic       force_pd_tx = 0, force_pd_rx = 0;
   logic       thr_empty = 0, tsr_empty = 0, rx_fifo_empty = 0, rx_hunt = 0;
   logic       thr_wr = 0, rx_line = 1, ring_in = 0, ri_int_clr = 0;
   logic       tx_pd, rx_pd, ri_irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   uart_auto_pd u_uart_auto_pd (
      .clk(clk), .rst_n(rst_n), .cfg_auto_en(cfg_auto_en),
      .force_pd_tx(force_pd_tx), .force_pd_rx(force_pd_rx),
      .thr_empty(thr_empty), .tsr_empty(tsr_empty),
      .rx_fifo_empty(rx_fifo_empty), .rx_hunt(rx_hunt), .thr_wr(thr_wr),
      .rx_line(rx_line), .ring_in(ring_in), .ri_int_clr(ri_int_clr),
      .tx_pd(tx_pd), .rx_pd(rx_pd), .ri_irq(ri_irq)
   );

   // {cfg[1:0], thr, tsr, fifo, hunt, ftx, frx, exp_tx, exp_rx}
   localparam logic [9:0] VEC [9] = '{
      10'b11_1111_00_11,
      10'b11_0111_00_01,
      10'b11_1001_00_00,
      10'b11_1110_00_10,
      10'b01_1111_00_00,
      10'b10_1111_00_00,
      10'b00_0000_10_10,
      10'b00_1111_01_01,
      10'b11_0000_11_11
   };

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      tick(3);
      chk("R1 tx_pd in reset", tx_pd, 1'b0);
      chk("R1 rx_pd in reset", rx_pd, 1'b0);
      chk("R1 ri_irq in reset", ri_irq, 1'b0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 ri_irq after release", ri_irq, 1'b0);

      // table walk: R2 R4 R6 R10
      foreach (VEC[i]) begin
         {cfg_auto_en, thr_empty, tsr_empty, rx_fifo_empty, rx_hunt,
          force_pd_tx, force_pd_rx} = VEC[i][9:2];
         tick(3);
         chk($sformatf("R2/R4/R6/R10 vec%0d tx_pd", i), tx_pd, VEC[i][1]);
         chk($sformatf("R2/R4/R6/R10 vec%0d rx_pd", i), rx_pd, VEC[i][0]);
      end

      // R3 entry timing
      force_pd_tx = 0; force_pd_rx = 0;
      cfg_auto_en = 2'b11; thr_empty = 0; tsr_empty = 1;
      rx_fifo_empty = 1; rx_hunt = 1;
      tick(2);
      chk("R3 tx busy before", tx_pd, 1'b0);
      thr_empty = 1;
      #1 chk("R3 tx not yet asleep", tx_pd, 1'b0);
      tick(1);
      chk("R3 tx asleep after one edge", tx_pd, 1'b1);

      // R5 write wakes combinationally
      thr_wr = 1;
      #1 chk("R5 tx wake same cycle", tx_pd, 1'b0);
      tick(1);
      thr_wr = 0;
      #1 chk("R5 tx awake after write", tx_pd, 1'b0);
      tick(1);
      chk("R3 tx re-enters", tx_pd, 1'b1);

      // R7 rx wake on line change
      chk("R6 rx asleep", rx_pd, 1'b1);
      rx_line = 0;
      tick(1);
      chk("R7 rx still asleep after 1 edge", rx_pd, 1'b1);
      tick(1);
      chk("R7 rx wakes after sync", rx_pd, 1'b0);
      tick(1);
      chk("R7 rx awake next cycle", rx_pd, 1'b0);
      tick(1);
      chk("R7 rx re-enters", rx_pd, 1'b1);
      chk("R7 tx unaffected", tx_pd, 1'b1);

      // R8 ring interrupt while asleep
      ring_in = 1;
      tick(2);
      chk("R8 irq not before sync", ri_irq, 1'b0);
      tick(1);
      chk("R8 irq set on rise", ri_irq, 1'b1);
      tick(4);
      chk("R8 irq held", ri_irq, 1'b1);
      ri_int_clr = 1;
      tick(1);
      ri_int_clr = 0;
      #1 chk("R8 irq cleared", ri_irq, 1'b0);
      ring_in = 0;
      tick(2);
      ri_int_clr = 1;
      tick(1);
      ri_int_clr = 0;
      #1 chk("R8 set wins over clear, fall edge", ri_irq, 1'b1);
      ri_int_clr = 1;
      tick(1);
      ri_int_clr = 0;
      #1 chk("R8 cleared again", ri_irq, 1'b0);

      // R9 disarm wakes both combinationally
      chk("R9 both asleep before", tx_pd & rx_pd, 1'b1);
      cfg_auto_en = 2'b01;
      #1 chk("R9 tx drops same cycle", tx_pd, 1'b0);
      chk("R9 rx drops same cycle", rx_pd, 1'b0);
      tick(3);
      chk("R2 stays awake with one bit", tx_pd | rx_pd, 1'b0);

      // R10 force while unarmed
      force_pd_rx = 1;
      #1 chk("R10 force rx same cycle", rx_pd, 1'b1);
      chk("R10 tx not forced", tx_pd, 1'b0);
      force_pd_rx = 0;

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule